// File: doc/BRIEF.md
# Configuration Image Stream Loader

This block loads a configuration image into a programmable target device that takes its image one byte at a time. A one-cycle start pulse sets off a fixed sequence. The block pulses a reset line to the target and waits a programmable settle time. It writes a single zero byte to the configuration port. It reads the image header from a byte-wide source memory to learn the payload length, streams the payload bytes to the port, and ends the stream with a short run of zero bytes. It then samples the target's error line.

When the error line is clear, the block waits a programmable ready time and then raises a flag that lets the normal interrupt path through. When the error line is set, the block stops in an error state and keeps that path shut. Source reads use a request/acknowledge handshake with at most one request in flight. Each port write is a one-cycle strobe with the byte on the data lines.

Top module: `cfg_image_loader`

## Requirements
- R1: A start pulse accepted while not busy produces exactly one `tgt_reset` strobe, one cycle wide, in the first cycle after the start pulse.
- R2: The first port write carries 0x00 and comes exactly `settle_cycles` + 2 cycles after the reset strobe.
- R3: The payload length is image bytes 0..3 taken as a big-endian 32-bit value (byte 0 is the most significant). The block makes exactly length + 6 port writes in total.
- R4: The block never requests source addresses 4 through 15. Those header bytes are reserved and ignored.
- R5: Payload byte i is read from source address 16 + i and written to the port in ascending order of i. The block writes one byte per strobe.
- R6: After the payload the block writes five 0x00 bytes on five consecutive cycles.
- R7: If `tgt_err` is high in the cycle after the last trailing write, `error` rises one cycle later (two cycles after the last write) and `irq_en` stays low.
- R8: If `tgt_err` is low in that cycle, `done` and `irq_en` rise exactly `ready_cycles` + 3 cycles after the last trailing write and hold until the next start.
- R9: `busy` is high from the reset strobe until `done` or `error` rises, and it is never high together with either of them.
- R10: A start pulse that arrives while `busy` is high is ignored. It causes no reset strobe and does not change the byte stream.
- R11: While `src_req` is high and no `src_ack` has come, `src_req` stays high and `src_addr` holds steady.
- R12: After reset, `busy`, `done`, `error`, `irq_en`, `port_we`, `src_req` and `tgt_reset` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| settle_cycles | input | CNT_W | Wait after the reset strobe, in cycles |
| ready_cycles | input | CNT_W | Wait after a clean error check, in cycles |
| src_req | output | 1 | Source read request, held until acknowledged |
| src_addr | output | ADDR_W | Source byte address |
| src_ack | input | 1 | Source data valid for the pending request |
| src_data | input | 8 | Source byte |
| tgt_reset | output | 1 | One-cycle reset strobe to the target |
| port_we | output | 1 | Configuration port write strobe |
| port_data | output | 8 | Configuration port byte |
| tgt_err | input | 1 | Target error line, sampled after the stream |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished cleanly |
| error | output | 1 | Load ended with the target reporting an error |
| irq_en | output | 1 | Normal interrupt path enabled |

## Verification
A second start pulse can land in the same cycle as a payload write strobe. The bench provokes this by raising `start` in the cycle of the fourth port write, with a source that answers after two cycles of latency. The case is judged by requiring that the run still shows a single reset strobe and a byte stream identical to that of an undisturbed run. The sweep also uses zero-latency acknowledges, where the data arrives in the same cycle the request is raised. This exercises back-to-back header fetches.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST,
      ST_SETTLE,
      ST_LEAD,
      ST_HREQ,
      ST_HEVAL,
      ST_PREQ,
      ST_PWR,
      ST_TRAIL,
      ST_CHECK,
      ST_READY,
      ST_DONE,
      ST_FAIL
   } ldr_state_e;
endpackage

// File: rtl/cfg_ldr_delay.sv
module cfg_ldr_delay #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] init,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= init;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/cfg_ldr_len.sv
module cfg_ldr_len #(
   parameter int BYTES      = 4,
   parameter bit BIG_ENDIAN = 1'b1,
   parameter int IDX_W      = $clog2(BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               we,
   input  logic [IDX_W-1:0]   idx,
   input  logic [7:0]         din,
   output logic [8*BYTES-1:0] value
);
   generate
      if (BIG_ENDIAN) begin : g_big
         always_ff @(posedge clk) begin
            if (!rst_n || clr) value <= '0;
            else if (we)       value <= {value[8*BYTES-9:0], din};
         end
         logic unused_idx;
         assign unused_idx = ^idx;
      end else begin : g_little
         always_ff @(posedge clk) begin
            if (!rst_n || clr) value <= '0;
            else if (we)       value[8*idx +: 8] <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
   import cfg_ldr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int LEN_BYTES = 4,
   parameter int HDR_BYTES = 16,
   parameter int TRAIL_N   = 5,
   parameter bit BIG_LEN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  settle_cycles,
   input  logic [CNT_W-1:0]  ready_cycles,
   output logic              src_req,
   output logic [ADDR_W-1:0] src_addr,
   input  logic              src_ack,
   input  logic [7:0]        src_data,
   output logic              tgt_reset,
   output logic              port_we,
   output logic [7:0]        port_data,
   input  logic              tgt_err,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic              irq_en
);
   localparam int LEN_W  = 8 * LEN_BYTES;
   localparam int HIDX_W = $clog2(LEN_BYTES);
   localparam int TR_W   = $clog2(TRAIL_N + 1);
   localparam logic [ADDR_W-1:0] PAY_BASE = ADDR_W'(HDR_BYTES);

   generate
      if (LEN_BYTES < 2 || HDR_BYTES < LEN_BYTES) begin : g_bad_hdr
         $fatal(1, "header must hold the length field and be at least two bytes");
      end
      if (TRAIL_N < 1 || ADDR_W <= $clog2(HDR_BYTES)) begin : g_bad_misc
         $fatal(1, "trailer count or address width out of range");
      end
   endgenerate

   ldr_state_e          st;
   logic [HIDX_W-1:0]   hidx;
   logic [LEN_W-1:0]    pcnt;
   logic [TR_W-1:0]     tcnt;
   logic [7:0]          dreg;
   logic [LEN_W-1:0]    pay_len;
   logic                settle_exp, ready_exp;

   cfg_ldr_len #(.BYTES(LEN_BYTES), .BIG_ENDIAN(BIG_LEN), .IDX_W(HIDX_W)) u_len (
      .clk(clk), .rst_n(rst_n), .clr(st == ST_RST),
      .we(st == ST_HREQ && src_ack), .idx(hidx), .din(src_data), .value(pay_len)
   );

   cfg_ldr_delay #(.CNT_W(CNT_W)) u_settle (
      .clk(clk), .rst_n(rst_n), .load(st == ST_RST),
      .init(settle_cycles), .expired(settle_exp)
   );

   cfg_ldr_delay #(.CNT_W(CNT_W)) u_ready (
      .clk(clk), .rst_n(rst_n), .load(st == ST_CHECK),
      .init(ready_cycles), .expired(ready_exp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         hidx <= '0;
         pcnt <= '0;
         tcnt <= '0;
         dreg <= '0;
      end else begin
         case (st)
            ST_IDLE, ST_DONE, ST_FAIL:
               if (start) st <= ST_RST;
            ST_RST: begin
               hidx <= '0;
               pcnt <= '0;
               tcnt <= '0;
               st   <= ST_SETTLE;
            end
            ST_SETTLE:
               if (settle_exp) st <= ST_LEAD;
            ST_LEAD:
               st <= ST_HREQ;
            ST_HREQ:
               if (src_ack) begin
                  if (hidx == HIDX_W'(LEN_BYTES - 1)) st <= ST_HEVAL;
                  else                                 hidx <= hidx + 1'b1;
               end
            ST_HEVAL:
               st <= (pay_len == '0) ? ST_TRAIL : ST_PREQ;
            ST_PREQ:
               if (src_ack) begin
                  dreg <= src_data;
                  st   <= ST_PWR;
               end
            ST_PWR: begin
               pcnt <= pcnt + LEN_W'(1);
               st   <= ((pcnt + LEN_W'(1)) == pay_len) ? ST_TRAIL : ST_PREQ;
            end
            ST_TRAIL:
               if (tcnt == TR_W'(TRAIL_N - 1)) st <= ST_CHECK;
               else                             tcnt <= tcnt + 1'b1;
            ST_CHECK:
               st <= tgt_err ? ST_FAIL : ST_READY;
            ST_READY:
               if (ready_exp) st <= ST_DONE;
            default:
               st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      src_req   = (st == ST_HREQ) || (st == ST_PREQ);
      src_addr  = (st == ST_HREQ) ? ADDR_W'(hidx) : PAY_BASE + ADDR_W'(pcnt);
      tgt_reset = (st == ST_RST);
      port_we   = (st == ST_LEAD) || (st == ST_PWR) || (st == ST_TRAIL);
      port_data = (st == ST_PWR) ? dreg : 8'h00;
      done      = (st == ST_DONE);
      error     = (st == ST_FAIL);
      irq_en    = (st == ST_DONE);
      busy      = !((st == ST_IDLE) || (st == ST_DONE) || (st == ST_FAIL));
   end

   // R1
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_reset |=> !tgt_reset);

   // R10
   restart_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tgt_reset) |=> !tgt_reset);

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req && !src_ack) |=> (src_req && $stable(src_addr)));

   // R4
   reserved_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_req |-> !((src_addr >= ADDR_W'(LEN_BYTES)) && (src_addr < PAY_BASE)));

   // R7
   err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !irq_en);

   // R9
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(done || error));
endmodule

// File: tb/cfg_image_loader_bench.sv
module cfg_image_loader_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] settle_cycles = '0;
   logic [15:0] ready_cycles = '0;
   logic        src_req;
   logic [15:0] src_addr;
   logic        src_ack = 1'b0;
   logic [7:0]  src_data = '0;
   logic        tgt_reset, port_we, busy, done, error, irq_en;
   logic [7:0]  port_data;
   logic        tgt_err = 1'b0;

   int vectors = 0;
   int miscompares = 0;
   int wb[$];
   int wc[$];

   always #4 clk = ~clk;

   cfg_image_loader u_cfg_image_loader (
      .clk(clk), .rst_n(rst_n), .start(start),
      .settle_cycles(settle_cycles), .ready_cycles(ready_cycles),
      .src_req(src_req), .src_addr(src_addr), .src_ack(src_ack), .src_data(src_data),
      .tgt_reset(tgt_reset), .port_we(port_we), .port_data(port_data),
      .tgt_err(tgt_err), .busy(busy), .done(done), .error(error), .irq_en(irq_en)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int pay(input int i);
      return (i * 37 + 11) & 255;
   endfunction

   function automatic logic [7:0] img(input int a, input int len);
      if (a < 4)       return 8'((len >> (8 * (3 - a))) & 255);
      else if (a < 16) return 8'(8'hA0 | a);
      else             return 8'(pay(a - 16));
   endfunction

   task automatic run(input int len, input int settle, input int rdy,
                      input bit err, input int lat, input bit poke);
      int  cyc = 0, nrst = 0, rst_cyc = -1, bad_addr = 0, busy_low = 0;
      int  w = 0, end_cyc = -1, pay_bad = 0, last;
      bit  finished = 1'b0;
      bit  zeros_ok;
      wb.delete();
      wc.delete();
      @(negedge clk);
      settle_cycles = 16'(settle);
      ready_cycles  = 16'(rdy);
      tgt_err       = err;
      start         = 1'b1;
      while (!finished && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         start = 1'b0;
         if (tgt_reset) begin
            if (nrst == 0) rst_cyc = cyc;
            nrst++;
         end
         if (port_we) begin
            if (poke && wb.size() == 3) start = 1'b1;
            wb.push_back(int'(port_data));
            wc.push_back(cyc);
         end
         if (src_req && src_addr >= 4 && src_addr < 16) bad_addr++;
         if (done || error) begin
            finished = 1'b1;
            end_cyc  = cyc;
         end else if (!busy) busy_low++;
         if (src_ack) src_ack = 1'b0;
         else if (src_req) begin
            if (w == lat) begin
               src_ack  = 1'b1;
               src_data = img(int'(src_addr), len);
               w = 0;
            end else w++;
         end
      end
      src_ack = 1'b0;
      chk(finished, "R9", "run reached done or error (watchdog)", int'(finished), 1);
      // R1 single strobe in first cycle
      chk(nrst == 1 && rst_cyc == 1, "R1", "reset strobes / cycle", nrst * 100 + rst_cyc, 101);
      // R10 second start during busy ignored
      if (poke) chk(nrst == 1, "R10", "strobes with start during busy", nrst, 1);
      // R3 write count from big-endian length
      chk(wb.size() == len + 6, "R3", "port write count", wb.size(), len + 6);
      // R2 leading dummy byte and its timing
      if (wb.size() > 0)
         chk(wb[0] == 0 && wc[0] - rst_cyc == settle + 2, "R2", "lead byte gap",
             wc[0] - rst_cyc + 1000 * wb[0], settle + 2);
      // R4 reserved header bytes
      chk(bad_addr == 0, "R4", "requests to reserved header", bad_addr, 0);
      if (wb.size() == len + 6) begin
         for (int i = 1; i <= len; i++) if (wb[i] != pay(i - 1)) pay_bad++;
         // R5 payload order and content
         chk(pay_bad == 0, "R5", "payload mismatches", pay_bad, 0);
         last = wb.size() - 1;
         zeros_ok = (wc[last] - wc[last - 4] == 4);
         for (int i = last - 4; i <= last; i++) if (wb[i] != 0) zeros_ok = 1'b0;
         // R6 trailing zero bytes
         chk(zeros_ok, "R6", "five consecutive trailing zeros", int'(zeros_ok), 1);
         if (err) begin
            // R7
            chk(error && !irq_en && end_cyc - wc[last] == 2, "R7", "error end gap",
                end_cyc - wc[last], 2);
         end else begin
            // R8
            chk(done && irq_en && end_cyc - wc[last] == rdy + 3, "R8", "done end gap",
                end_cyc - wc[last], rdy + 3);
         end
      end
      // R9 busy over the whole run and released after
      chk(busy_low == 0, "R9", "cycles with busy low mid-run", busy_low, 0);
      @(negedge clk);
      chk(!busy && (done == !err) && (error == err), "R9", "flags held after end",
          int'({busy, done, error}), err ? 1 : 2);
   endtask

   initial begin
      int lens[4] = '{0, 1, 3, 261};
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(!busy && !done && !error && !irq_en && !port_we && !src_req && !tgt_reset,
          "R12", "outputs during reset",
          int'({busy, done, error, irq_en, port_we, src_req, tgt_reset}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !error && !irq_en && !port_we && !src_req && !tgt_reset,
          "R12", "outputs after reset",
          int'({busy, done, error, irq_en, port_we, src_req, tgt_reset}), 0);
      foreach (lens[k])
         for (int s = 0; s <= 3; s += 3)
            for (int r = 0; r <= 2; r += 2)
               for (int e = 0; e <= 1; e++)
                  for (int l = 0; l <= 2; l += 2)
                     run(lens[k], s, r, e[0], l, (l == 2));
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule